// File: doc/BRIEF.md
# I2C Slave Address and Extension-Code Detector

This block serves the slave side of an I2C byte engine. Its inputs are strobes that are already synchronised: a START strobe, rising and falling SCL strobes, and the sampled SDA level. After each START it shifts in the first byte, MSB first, as a 7-bit address followed by the R/W bit. It compares the address with a programmable own-address register. A hit or a reserved extension prefix raises a status flag and a one-cycle interrupt, both timed at the eighth falling SCL edge.

Extension codes are addresses whose upper four bits are all zeros or all ones. They are flagged on their own, apart from the plain match. A 10-bit header that equals the programmed header sets both flags. A release command puts the slave in standby, where it ignores the bus until the next START.

For a transmitted byte, the engine loads the byte it is about to send. The same shift register captures the SDA levels actually present on the bus. A difference in any bit flags a transmit error.

Top module: `slv_addr_watch`

## Requirements
- R1: Bits are taken on `scl_rise`, MSB first. When received bits [7:1] equal `own_addr_q[7:1]`, `status[4]` (hit) is set.
- R2: When the upper four received bits are 0000 or 1111, `status[5]` (extension) is set.
- R3: If hit or extension is true, `irq` is high for exactly one cycle, in the cycle after the eighth `scl_fall` of the address byte. Otherwise it stays low. Extra SCL strobes after the eighth bit raise no second pulse.
- R4: Receiving any address, extension codes included, leaves `own_addr_q` unchanged. Only `addr_wr` changes it.
- R5: With `own_addr_q` = 11110xx0 and a received header 11110xx with the same xx, both `status[5]` and `status[4]` are set, whatever the R/W bit.
- R6: `status[3]` is set only for the received byte 0x00 (general call). `status[0]` holds the received R/W bit.
- R7: `active` goes high on a hit or an extension code. `release_cmd` clears `active` and all status bits.
- R8: After `release_cmd`, all SCL/SDA strobes are ignored, with no `irq` and no flags, until `start_det`.
- R9: `start_det` clears the bit count and all status bits. Bits received before it are discarded.
- R10: After `tx_load`, eight captured bits are compared with `tx_data` at the eighth `scl_fall`. `tx_err` goes high if any bit differs. `tx_load` or `start_det` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START condition strobe |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Synchronised SDA level |
| addr_wr | input | 1 | Write strobe for own-address register |
| addr_wdata | input | 8 | Own-address write value (bits 7:1 used) |
| release_cmd | input | 1 | Drop to standby until next START |
| tx_load | input | 1 | Begin a transmit check byte |
| tx_data | input | 8 | Byte being transmitted |
| own_addr_q | output | 8 | Own-address register |
| status | output | 8 | [5] ext, [4] hit, [3] general call, [0] R/W |
| irq | output | 1 | Address-phase interrupt pulse |
| active | output | 1 | Slave participates in transfer |
| tx_err | output | 1 | Transmit mismatch flag |

## Verification
A bad bit counter or shift register would give a wrong flag in the status byte, or an `irq` pulse missing or in the wrong cycle. Either is visible one cycle after the eighth falling strobe. A standby or phase register stuck in the wrong state would show as an `irq` or flags after a release, or as silence after a START, both within one byte of stimulus. A reference register that is corrupted shows as a wrong `tx_err` right after the eighth falling strobe of the checked byte.

// File: rtl/slvad_pkg.sv
package slvad_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_TX   = 2'd2,
      PH_DONE = 2'd3
   } slvad_phase_e;
endpackage

// File: rtl/slvad_shift.sv
module slvad_shift #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              scl_rise,
   input  logic              sda,
   output logic [BYTE_W-1:0] shreg,
   output logic              full
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         shreg <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (en && scl_rise && (cnt_q < CNT_W'(BYTE_W))) begin
         shreg <= {shreg[BYTE_W-2:0], sda};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign full = (cnt_q == CNT_W'(BYTE_W));
endmodule

// File: rtl/slvad_decode.sv
module slvad_decode #(
   parameter int ADDR_W   = 7,
   parameter int PFX_W    = 4,
   parameter bit GCALL_EN = 1'b1,
   localparam int BYTE_W  = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] own_addr,
   output logic              hit,
   output logic              ext,
   output logic              gcall,
   output logic              rw
);
   logic [PFX_W-1:0] pfx;

   assign pfx = rx_byte[BYTE_W-1 -: PFX_W];
   assign hit = (rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
   assign ext = (pfx == '0) || (pfx == '1);
   assign rw  = rx_byte[0];

   generate
      if (GCALL_EN) begin : g_gcall
         assign gcall = (rx_byte == '0);
      end else begin : g_no_gcall
         assign gcall = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/slvad_txcmp.sv
module slvad_txcmp #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BYTE_W-1:0] ref_in,
   input  logic              check,
   input  logic [BYTE_W-1:0] cap,
   output logic              err
);
   logic [BYTE_W-1:0] ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         err   <= 1'b0;
      end else if (clr) begin
         err   <= 1'b0;
      end else if (load) begin
         ref_q <= ref_in;
         err   <= 1'b0;
      end else if (check) begin
         err   <= (cap != ref_q);
      end
   end
endmodule

// File: rtl/slv_addr_watch.sv
module slv_addr_watch #(
   parameter int ADDR_W   = 7,
   parameter int PFX_W    = 4,
   parameter int STAT_W   = 8,
   parameter int EXT_BIT  = 5,
   parameter int HIT_BIT  = 4,
   parameter int GC_BIT   = 3,
   parameter int RW_BIT   = 0,
   parameter bit GCALL_EN = 1'b1,
   localparam int BYTE_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_in,
   input  logic              addr_wr,
   input  logic [BYTE_W-1:0] addr_wdata,
   input  logic              release_cmd,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] own_addr_q,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic              active,
   output logic              tx_err
);
   import slvad_pkg::*;

   generate
      if (PFX_W < 1 || PFX_W > ADDR_W) begin : g_bad_pfx
         $error("PFX_W must lie in 1..ADDR_W");
      end
      if (EXT_BIT >= STAT_W || HIT_BIT >= STAT_W || GC_BIT >= STAT_W || RW_BIT >= STAT_W) begin : g_bad_pos
         $error("status bit position out of range");
      end
      if (EXT_BIT == HIT_BIT || GC_BIT == RW_BIT || EXT_BIT == GC_BIT || HIT_BIT == RW_BIT) begin : g_dup_pos
         $error("status bit positions collide");
      end
   endgenerate

   slvad_phase_e      phase_q;
   logic              standby_q;
   logic              f_hit_q, f_ext_q, f_gc_q, f_rw_q;
   logic [BYTE_W-1:0] shreg;
   logic              full;
   logic              d_hit, d_ext, d_gc, d_rw;
   logic              tx_go, sh_clr, sh_en, byte_end, tx_check;

   assign tx_go    = tx_load && !standby_q && !start_det && !release_cmd;
   assign sh_clr   = start_det || tx_go;
   assign sh_en    = !standby_q && (phase_q == PH_ADDR || phase_q == PH_TX);
   assign byte_end = scl_fall && full && !standby_q;
   assign tx_check = byte_end && (phase_q == PH_TX) && !start_det && !release_cmd;

   slvad_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sh_clr),
      .en       (sh_en),
      .scl_rise (scl_rise),
      .sda      (sda_in),
      .shreg    (shreg),
      .full     (full)
   );

   slvad_decode #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .GCALL_EN(GCALL_EN)) u_dec (
      .rx_byte  (shreg),
      .own_addr (own_addr_q),
      .hit      (d_hit),
      .ext      (d_ext),
      .gcall    (d_gc),
      .rw       (d_rw)
   );

   slvad_txcmp #(.BYTE_W(BYTE_W)) u_txc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_det),
      .load   (tx_go),
      .ref_in (tx_data),
      .check  (tx_check),
      .cap    (shreg),
      .err    (tx_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_addr_q <= '0;
      else if (addr_wr) own_addr_q <= addr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         standby_q <= 1'b0;
         f_hit_q   <= 1'b0;
         f_ext_q   <= 1'b0;
         f_gc_q    <= 1'b0;
         f_rw_q    <= 1'b0;
         irq       <= 1'b0;
         active    <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (start_det) begin
            phase_q   <= PH_ADDR;
            standby_q <= 1'b0;
            f_hit_q   <= 1'b0;
            f_ext_q   <= 1'b0;
            f_gc_q    <= 1'b0;
            f_rw_q    <= 1'b0;
            active    <= 1'b0;
         end else if (release_cmd) begin
            phase_q   <= PH_IDLE;
            standby_q <= 1'b1;
            f_hit_q   <= 1'b0;
            f_ext_q   <= 1'b0;
            f_gc_q    <= 1'b0;
            f_rw_q    <= 1'b0;
            active    <= 1'b0;
         end else if (tx_go) begin
            phase_q <= PH_TX;
         end else if (byte_end && phase_q == PH_ADDR) begin
            phase_q <= PH_DONE;
            f_hit_q <= d_hit;
            f_ext_q <= d_ext;
            f_gc_q  <= d_gc;
            f_rw_q  <= d_rw;
            irq     <= d_hit || d_ext;
            active  <= d_hit || d_ext;
         end else if (tx_check) begin
            phase_q <= PH_DONE;
         end
      end
   end

   always_comb begin
      status          = '0;
      status[EXT_BIT] = f_ext_q;
      status[HIT_BIT] = f_hit_q;
      status[GC_BIT]  = f_gc_q;
      status[RW_BIT]  = f_rw_q;
   end
endmodule

module slv_addr_watch_chk #(
   parameter int BYTE_W  = 8,
   parameter int STAT_W  = 8,
   parameter int EXT_BIT = 5,
   parameter int HIT_BIT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_det,
   input logic              scl_fall,
   input logic              addr_wr,
   input logic              release_cmd,
   input logic              standby_q,
   input logic [BYTE_W-1:0] own_addr_q,
   input logic [STAT_W-1:0] status,
   input logic              irq,
   input logic              active
);
   p_irq_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(scl_fall));
   p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_wr |=> $stable(own_addr_q));
   p_hit_with_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[HIT_BIT]) |-> irq);
   p_ext_with_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[EXT_BIT]) |-> irq);
   p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (release_cmd && !start_det) |=> (!active && status == '0));
   p_standby_noirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      standby_q |-> !irq);
   p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (status == '0 && !active));
endmodule

bind slv_addr_watch slv_addr_watch_chk #(
   .BYTE_W(BYTE_W), .STAT_W(STAT_W), .EXT_BIT(EXT_BIT), .HIT_BIT(HIT_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_det   (start_det),
   .scl_fall    (scl_fall),
   .addr_wr     (addr_wr),
   .release_cmd (release_cmd),
   .standby_q   (standby_q),
   .own_addr_q  (own_addr_q),
   .status      (status),
   .irq         (irq),
   .active      (active)
);

// File: tb/sim_slv_addr_watch.sv
`timescale 1ns/1ps
module sim_slv_addr_watch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_det = 0, scl_rise = 0, scl_fall = 0, sda_in = 0;
   logic       addr_wr = 0, release_cmd = 0, tx_load = 0;
   logic [7:0] addr_wdata = 0, tx_data = 0;
   logic [7:0] own_addr_q, status;
   logic       irq, active, tx_err;

   int total = 0;
   int bad   = 0;
   int irq_cnt = 0;

   always #2.5 clk = ~clk;

   slv_addr_watch u0 (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .sda_in(sda_in), .addr_wr(addr_wr),
      .addr_wdata(addr_wdata), .release_cmd(release_cmd), .tx_load(tx_load),
      .tx_data(tx_data), .own_addr_q(own_addr_q), .status(status), .irq(irq),
      .active(active), .tx_err(tx_err)
   );

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   // own address, received byte, hit, ext, general call
   localparam logic [18:0] TBL [11] = '{
      {8'hA0, 8'hA0, 1'b1, 1'b0, 1'b0},
      {8'hA0, 8'hA1, 1'b1, 1'b0, 1'b0},
      {8'hA0, 8'hA2, 1'b0, 1'b0, 1'b0},
      {8'hA0, 8'h00, 1'b0, 1'b1, 1'b1},
      {8'hA0, 8'h01, 1'b0, 1'b1, 1'b0},
      {8'hA0, 8'hF0, 1'b0, 1'b1, 1'b0},
      {8'hF2, 8'hF2, 1'b1, 1'b1, 1'b0},
      {8'hF2, 8'hF3, 1'b1, 1'b1, 1'b0},
      {8'hF2, 8'hF6, 1'b0, 1'b1, 1'b0},
      {8'h0E, 8'h0E, 1'b1, 1'b1, 1'b0},
      {8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_det = 1;
      @(negedge clk) start_det = 0;
   endtask

   task automatic write_addr(input logic [7:0] a);
      @(negedge clk) begin addr_wr = 1; addr_wdata = a; end
      @(negedge clk) addr_wr = 0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         @(negedge clk) begin sda_in = b[i]; scl_rise = 1; end
         @(negedge clk) begin scl_rise = 0; scl_fall = 1; end
         @(negedge clk) scl_fall = 0;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset status", status, 8'h00);
      chk("R7 reset active", active, 0);
      chk("R10 reset tx_err", tx_err, 0);
      chk("R3 reset irq", irq, 0);

      // table walk
      for (int k = 0; k < 11; k++) begin
         logic [7:0] sva, rx;
         logic eh, ee, eg;
         {sva, rx, eh, ee, eg} = TBL[k];
         write_addr(sva);
         pulse_start();
         irq_cnt = 0;
         send_bits(rx, 8);
         @(negedge clk);
         chk("R1 hit flag", status[4], eh);
         chk("R2 ext flag", status[5], ee);
         chk("R6 gcall flag", status[3], eg);
         chk("R6 rw bit", status[0], rx[0]);
         chk("R3 irq count", irq_cnt, (eh | ee) ? 1 : 0);
         chk("R7 active", active, eh | ee);
         chk("R4 own addr kept", own_addr_q, sva);
         if (sva == 8'hF2 && rx[7:1] == 7'h79) chk("R5 both flags", {status[5], status[4]}, 2'b11);
      end

      // extra strobes after the 8th bit: no second pulse
      write_addr(8'hA0);
      pulse_start();
      irq_cnt = 0;
      send_bits(8'hA0, 8);
      send_bits(8'hFF, 3);
      chk("R3 one pulse per byte", irq_cnt, 1);

      // release: flags clear, bus ignored
      @(negedge clk) release_cmd = 1;
      @(negedge clk) release_cmd = 0;
      chk("R7 release clears status", status, 8'h00);
      chk("R7 release clears active", active, 0);
      irq_cnt = 0;
      send_bits(8'hA0, 8);
      @(negedge clk);
      chk("R8 no irq in standby", irq_cnt, 0);
      chk("R8 no flags in standby", status, 8'h00);

      // START re-arms
      pulse_start();
      irq_cnt = 0;
      send_bits(8'hA0, 8);
      @(negedge clk);
      chk("R9 rearm irq", irq_cnt, 1);
      chk("R9 rearm hit", status[4], 1);

      // START mid-byte discards partial bits, clears flags
      pulse_start();
      chk("R9 start clears flags", status, 8'h00);
      send_bits(8'h00, 4);
      pulse_start();
      irq_cnt = 0;
      send_bits(8'hA0, 8);
      @(negedge clk);
      chk("R9 partial discarded hit", status[4], 1);
      chk("R9 partial discarded ext", status[5], 0);

      // transmit check
      @(negedge clk) begin tx_load = 1; tx_data = 8'h5A; end
      @(negedge clk) tx_load = 0;
      send_bits(8'h5A, 8);
      @(negedge clk);
      chk("R10 tx equal no err", tx_err, 0);
      @(negedge clk) begin tx_load = 1; tx_data = 8'h5A; end
      @(negedge clk) tx_load = 0;
      send_bits(8'h5B, 8);
      @(negedge clk);
      chk("R10 tx mismatch err", tx_err, 1);
      @(negedge clk) begin tx_load = 1; tx_data = 8'h11; end
      @(negedge clk) tx_load = 0;
      chk("R10 load clears err", tx_err, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule